// File: doc/BRIEF.md
# Delta-Sigma Converter Output Sequencer

This block is the device-side control for a converter that repeats one fixed cycle: a conversion of fixed length, a low-power sleep that holds the result, and a serial readout. A conversion timer of parameterised length stands in for the modulator and filter. When it expires, the block captures a result word made of a magnitude, a sign flag and an extended-range flag. The block stays asleep for as long as the host keeps chip select high. When the host pulls chip select low, the 24-bit frame is shifted out on SDO under a host-driven serial clock.

The chip select and serial clock arrive asynchronously. Both are synchronised to the system clock, and their edges are detected on the synchronised copies. SDO carries an output-enable that stands for the tri-state control. While chip select is low and no readout is in progress, SDO shows a busy/done status bit. A completed readout starts a new conversion, and so does a chip-select rise in the middle of a readout. No data port has back-pressure: the result inputs are sampled in the single cycle in which the timer expires, and the serial side runs only at the pace of the host clock.

Top module: `cvt_out_seq`

## Requirements
- R1: After reset the block is converting. While converting and selected (cs_n low), SDO is 1 (status "busy").
- R2: sdo_oe is 0 while cs_n has been high for at least three system clocks, and 1 while cs_n has been low for at least three. SDO reads 0 whenever sdo_oe is 0.
- R3: A conversion lasts exactly CONV_CYCLES system clocks. After reset, `converting` is still 1 after CONV_CYCLES-1 clocks and is 0 after CONV_CYCLES clocks.
- R4: While cs_n stays high after a conversion, the block stays asleep with no time limit. The frame later read out is the one captured when the conversion ended, even if the result inputs change during sleep.
- R5: Frame bits, first out to last out: bit 23 is the status (0 = done), bit 22 is always 0, bit 21 is res_sign, bit 20 is res_over, and bits 19..0 are res_data, most significant bit first.
- R6: SDO changes only after a falling SCK edge. A rising SCK edge leaves SDO unchanged.
- R7: After the 24th falling SCK edge a new conversion starts: `converting` goes to 1 and SDO shows 1.
- R8: Extra SCK pulses after the 24th, up to 8 of them, shift out constant 1s.
- R9: A rising cs_n during readout abandons the frame and starts a new conversion. The next frame carries the inputs captured at the end of that new conversion.
- R10: The first conversion after reset yields a frame flagged invalid: sign 0, extended-range flag 1, data all zero (frame value 24'h100000).
- R11: In sleep with cs_n low, SDO shows 0 (status "done") before the first SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts a conversion |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Host serial clock, asynchronous |
| res_data | input | DATA_W | Conversion magnitude |
| res_sign | input | 1 | Sign flag, 1 = positive |
| res_over | input | 1 | Extended-range flag |
| sdo | output | 1 | Serial data / status out |
| sdo_oe | output | 1 | Output enable for SDO (0 = high impedance) |
| converting | output | 1 | High while a conversion is running |

## Verification
The bench builds the block with CONV_CYCLES = 150 and the default DATA_W = 20. That conversion length is longer than a full run of eight trailing SCK pulses at the slowest random half-period, so the constant-high tail can be read while the next conversion is still busy. It is also short enough that exact conversion-length checks, long sleeps and several random frames fit in a short run. Random SCK half-periods of 4 to 8 system clocks exercise the synchroniser margin, and the directed cases cover the invalid first frame, holding a result through sleep and aborting a readout.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } seq_state_t;

  localparam int FLAG_BITS = 4;
endpackage

// File: rtl/cvt_sync_edge.sv
module cvt_sync_edge #(
  parameter logic INIT = 1'b0,
  parameter bit   RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic edge_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= INIT;
      s2 <= INIT;
      s3 <= INIT;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q = s2;

  generate
    if (RISE) begin : g_rise
      assign edge_o = s2 & ~s3;
    end else begin : g_fall
      assign edge_o = ~s2 & s3;
    end
  endgenerate
endmodule

// File: rtl/cvt_conv_timer.sv
module cvt_conv_timer #(
  parameter int CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= RELOAD;
      busy <= 1'b1;
    end else if (start) begin
      cnt  <= RELOAD;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/cvt_frame_shifter.sv
module cvt_frame_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= word;
    else if (shift) sr <= {sr[W-2:0], 1'b1};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/cvt_out_seq.sv
module cvt_out_seq
  import cvt_seq_pkg::*;
#(
  parameter int DATA_W      = 20,
  parameter int CONV_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_sign,
  input  logic              res_over,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              converting
);
  localparam int FRAME_W = DATA_W + FLAG_BITS;
  localparam int BC_W    = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(FRAME_W - 1);
  localparam logic [1:0] SYNC_INIT = 2'b10;  // [1] chip select idles high, [0] sck idles low
  localparam logic [1:0] SYNC_RISE = 2'b10;  // chip select: rising edge; sck: falling edge

  logic [1:0] raw_in, syn_q, syn_edge;
  assign raw_in = {cs_n, sck};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_sync
      cvt_sync_edge #(.INIT(SYNC_INIT[g]), .RISE(SYNC_RISE[g])) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(syn_q[g]), .edge_o(syn_edge[g])
      );
    end
  endgenerate

  logic cs_s, cs_rise, sck_fall;
  assign cs_s     = syn_q[1];
  assign cs_rise  = syn_edge[1];
  assign sck_fall = syn_edge[0];

  seq_state_t      state;
  logic [BC_W-1:0] bit_cnt;
  logic            first_q;
  logic            in_dout, tm_done, restart, ld, sh, sh_msb;
  logic [FRAME_W-1:0] cap_word;

  assign in_dout = (state == ST_DOUT);
  assign restart = in_dout && (cs_rise || (sck_fall && bit_cnt == LAST_BIT));
  assign ld      = (state == ST_CONV) && tm_done;
  assign sh      = in_dout && sck_fall && !cs_rise;

  always_comb begin
    if (first_q) cap_word = {3'b000, 1'b1, {DATA_W{1'b0}}};
    else         cap_word = {2'b00, res_sign, res_over, res_data};
  end

  cvt_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(restart), .done(tm_done)
  );

  cvt_frame_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld), .word(cap_word), .shift(sh), .msb(sh_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CONV;
      bit_cnt <= '0;
      first_q <= 1'b1;
    end else begin
      unique case (state)
        ST_CONV: if (tm_done) begin
          state   <= ST_SLEEP;
          first_q <= 1'b0;
        end
        ST_SLEEP: if (!cs_s) begin
          state   <= ST_DOUT;
          bit_cnt <= '0;
        end
        ST_DOUT: begin
          if (restart)       state   <= ST_CONV;
          else if (sck_fall) bit_cnt <= bit_cnt + 1'b1;
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  assign converting = (state == ST_CONV);
  assign sdo_oe     = ~cs_s;
  assign sdo        = sdo_oe & (in_dout ? sh_msb : converting);
endmodule

// File: rtl/cvt_out_seq_chk.sv
module cvt_out_seq_chk #(
  parameter int CONV_CYCLES = 2048
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic converting,
  input logic sdo,
  input logic sdo_oe,
  input logic in_dout,
  input logic sck_fall,
  input logic cs_rise,
  input logic tm_done
);
  localparam int LW = $clog2(CONV_CYCLES + 1) + 1;
  logic [LW-1:0] spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          spent <= '0;
    else if (converting) spent <= spent + 1'b1;
    else                 spent <= '0;
  end

  p_busy_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && sdo_oe) |-> sdo);

  p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (!sdo_oe && !sdo));

  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> (spent < LW'(CONV_CYCLES)));

  p_capture_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tm_done |=> !converting);

  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dout && !sck_fall) |=> ($stable(sdo) || $past(cs_rise) || cs_rise));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dout && cs_rise) |=> converting);
endmodule

bind cvt_out_seq cvt_out_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .converting(converting), .sdo(sdo),
  .sdo_oe(sdo_oe), .in_dout(in_dout), .sck_fall(sck_fall), .cs_rise(cs_rise),
  .tm_done(tm_done)
);

// File: tb/sim_cvt_out_seq.sv
`timescale 1ns/1ps
module sim_cvt_out_seq;
  localparam int DW = 20;
  localparam int CC = 150;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic res_sign = 1'b0, res_over = 1'b0;
  logic sdo, sdo_oe, converting;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [23:0] pend;

  cvt_out_seq #(.DATA_W(DW), .CONV_CYCLES(CC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .res_data(res_data),
    .res_sign(res_sign), .res_over(res_over), .sdo(sdo), .sdo_oe(sdo_oe),
    .converting(converting)
  );

  always #4 clk = ~clk;

  function automatic logic [23:0] mk_frame(input logic [DW-1:0] d, input logic s, input logic o);
    return {2'b00, s, o, d};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive fresh random result inputs; the frame they will produce is recorded
  task automatic new_inputs();
    res_data = DW'($urandom);
    res_sign = 1'($urandom);
    res_over = 1'($urandom);
    pend = mk_frame(res_data, res_sign, res_over);
  endtask

  // stop = 24: full frame plus 8 trailing pulses; otherwise abort after stop falls
  task automatic read_frame(input logic [23:0] exp, input int stop, input string tag);
    logic [23:0] got;
    logic prev;
    int h;
    got = '0;
    cs_n = 1'b0;
    tick(6);
    chk("R11 selected sleep shows done", {31'd0, sdo}, 32'd0);
    got[23] = sdo;
    for (int i = 1; i <= stop; i++) begin
      h = 4 + int'($urandom % 5);
      prev = sdo;
      sck = 1'b1;
      tick(h);
      if (i % 6 == 1) chk("R6 rising edge keeps sdo", {31'd0, sdo}, {31'd0, prev});
      sck = 1'b0;
      tick(h);
      if (i < 24) got[23-i] = sdo;
    end
    if (stop >= 24) begin
      chk({tag, " R5 frame"}, {8'd0, got}, {8'd0, exp});
      chk("R7 restart after last bit", {30'd0, converting, sdo}, 32'd3);
      new_inputs();
      for (int j = 0; j < 8; j++) begin
        h = 4 + int'($urandom % 5);
        sck = 1'b1; tick(h);
        sck = 1'b0; tick(h);
        chk("R8 trailing bit high", {31'd0, sdo}, 32'd1);
      end
      cs_n = 1'b1;
    end else begin
      chk({tag, " R5 partial frame"}, {26'd0, got[23:18]}, {26'd0, exp[23:18]});
      cs_n = 1'b1;
      new_inputs();
      tick(5);
      chk("R9 abort starts conversion", {31'd0, converting}, 32'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    res_data = DW'($urandom);
    pend = 24'h100000;  // invalid first frame
    tick(5);
    rst_n = 1'b1;
    cs_n = 1'b0;
    tick(4);
    chk("R1 busy status after reset", {30'd0, converting, sdo}, 32'd3);
    chk("R2 selected enables sdo", {31'd0, sdo_oe}, 32'd1);
    cs_n = 1'b1;
    tick(4);
    chk("R2 deselect disables sdo", {30'd0, sdo_oe, sdo}, 32'd0);
    tick(CC - 1 - 8);
    chk("R3 still converting at CC-1", {31'd0, converting}, 32'd1);
    tick(1);
    chk("R3 done at CC", {31'd0, converting}, 32'd0);
    tick(10);
    read_frame(pend, 24, "R10 invalid first");

    for (int k = 0; k < 6; k++) begin
      tick(CC + 10);
      read_frame(pend, 24, "random");
    end

    // R4: change inputs during a long sleep
    begin
      logic [23:0] held;
      tick(CC + 10);
      held = pend;
      res_data = ~res_data;
      res_sign = ~res_sign;
      tick(400);
      chk("R4 still asleep", {31'd0, converting}, 32'd0);
      read_frame(held, 24, "R4 held");
    end

    // R9: abort, then the next frame carries the newly captured inputs
    tick(CC + 10);
    read_frame(pend, 5, "R9 before abort");
    tick(CC + 10);
    read_frame(pend, 24, "R9 after abort");

    tick(CC + 10);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule